// File: doc/BRIEF.md
# Real-Time Clock Interrupt Status Unit

This block gathers the events of a real-time clock and turns them into readable status and one active-low interrupt pin. Six tick inputs, one from each counter rollover (once per second, once per minute and so on), set six periodic flags. These flags are set whether or not any interrupt is enabled, and any chip-selected access to their register clears them. A separate sticky periodic-pending bit in the main status register is set only by ticks whose enable is on. That bit drives the interrupt, and the host clears it by writing a one to it.

An alarm event input sets a sticky alarm-pending bit. That bit reaches the pin only when the alarm enable is on. A power-fail input, gated by chip select so that it cannot cut into a bus access in progress, sets a power-fail bit when its enable is on. The bit holds until the power-fail input is released. Host software reaches the registers over a simple bus with chip select, read and write strobes and a five-bit address. A bank-select bit inside the main status register chooses between two register banks.

Register layout. Main status is at address 00h in both banks. Bank 0 has the periodic flag register at 03h. Bank 1 has the periodic enables at 03h, the alarm and power-fail enables at 04h, and an output-mode byte at 02h. Main status bits are: bit 0 interrupt active (read-only), bit 1 power-fail (read-only), bit 2 periodic pending (write one to clear), bit 3 alarm pending (write one to clear), bit 6 bank select (read/write). All other bits read 0.

Top module: `rtc_irq_status`

## Requirements
- R1: After reset, all flags, enables, the bank-select bit and the output-mode byte are 0, and irqN is high.
- R2: A one-cycle pulse on tickIn[i] sets bit i of the periodic flag register (bank 0, address 03h) on the next clock edge. This happens whatever the enables hold.
- R3: A chip-selected read or write of the periodic flag register clears all six flags at the end of that cycle. A read returns the value from before the clear. A tick that arrives in the same cycle as the access survives the clear.
- R4: Bits 5:0 of the periodic-enable register (bank 1, address 03h) enable the ticks one by one. An enabled tick sets main-status bit 2. A disabled tick leaves bit 2 and irqN unchanged.
- R5: Main-status bit 2 clears only when a one is written to it. Writing 0 to it, turning all periodic enables off, or leaving the periodic flags uncleared all leave it set.
- R6: alarmEvt sets main-status bit 3 whatever the enable holds. Bit 3 drives the pin only while bit 0 of the alarm/power-fail enable register (bank 1, address 04h) is 1. Writing a one to bit 3 clears it.
- R7: Bit 1 of register 04h (bank 1) enables the power-fail interrupt. Main-status bit 1 sets when pwrFail is high, the enable is on and chipSel is low. It stays set while pwrFail stays high and clears on the edge after pwrFail goes low.
- R8: irqN is low exactly while status bit 1 is set, or status bit 2 is set, or both status bit 3 and the alarm enable are set. Main-status bit 0 reads 1 exactly while irqN is low.
- R9: Main-status bit 6 is the bank select and is written along with the rest of the main status register. Main status reads the same at 00h in both banks. Address 03h gives the periodic flag register in bank 0 and the periodic-enable register in bank 1.
- R10: The output-mode byte (bank 1, address 02h) is plain 8-bit read/write storage and has no effect on irqN.
- R11: With chipSel low, writes change nothing, reads return 0 and periodic flags are not cleared. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickIn | input | 6 | One-cycle rollover ticks, one per counter |
| alarmEvt | input | 1 | One-cycle alarm match event |
| pwrFail | input | 1 | Power-fail sense, high while power is failing |
| chipSel | input | 1 | Chip select, high during a bus access |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| addr | input | 5 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational, 0 when not reading |
| irqN | output | 1 | Active-low interrupt |

## Verification
The periodic path is driven by single ticks and by ticks on several bits at once, with enables both off and partly on. This separates the always-tracking periodic flags from the enable-filtered pending bit. Clearing is tried by reads, by writes, by a tick that lands in the cycle of a clearing access, and by writing zeros to the pending bits, which tells a genuine write-one-to-clear apart from plain overwrite. The power-fail input is raised once while chip select is held high and once while it is low. Accesses without chip select, or to unmapped addresses, show that stray bus activity changes nothing.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int MS_IRQ   = 0;
  localparam int MS_PFAIL = 1;
  localparam int MS_PER   = 2;
  localparam int MS_ALARM = 3;
  localparam int MS_BANK  = 6;

  localparam logic [4:0] A_MAIN  = 5'h00;
  localparam logic [4:0] A_OMODE = 5'h02;
  localparam logic [4:0] A_PER   = 5'h03;
  localparam logic [4:0] A_ICR1  = 5'h04;

  typedef enum logic [2:0] {
    RS_NONE, RS_MAIN, RS_PFLAG, RS_ICR0, RS_ICR1, RS_OMODE
  } rdSel_e;

  typedef struct packed {
    logic   perAccess;
    logic   mainWr;
    logic   icr0Wr;
    logic   icr1Wr;
    logic   omWr;
    rdSel_e rdSel;
  } strobes_t;
endpackage

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              chipSel,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bankSel,
  output strobes_t          stb
);
  logic rdOk, wrOk, isMain, isOm, isP3, isIcr1;

  always_comb begin
    rdOk   = chipSel & rdEn;
    wrOk   = chipSel & wrEn;
    isMain = (addr == ADDR_W'(A_MAIN));
    isOm   = (addr == ADDR_W'(A_OMODE)) & bankSel;
    isP3   = (addr == ADDR_W'(A_PER));
    isIcr1 = (addr == ADDR_W'(A_ICR1)) & bankSel;

    stb.perAccess = (rdOk | wrOk) & isP3 & ~bankSel;
    stb.mainWr    = wrOk & isMain;
    stb.icr0Wr    = wrOk & isP3 & bankSel;
    stb.icr1Wr    = wrOk & isIcr1;
    stb.omWr      = wrOk & isOm;

    stb.rdSel = RS_NONE;
    if (rdOk) begin
      if (isMain)              stb.rdSel = RS_MAIN;
      else if (isP3 & ~bankSel) stb.rdSel = RS_PFLAG;
      else if (isP3)           stb.rdSel = RS_ICR0;
      else if (isIcr1)         stb.rdSel = RS_ICR1;
      else if (isOm)           stb.rdSel = RS_OMODE;
    end
  end
endmodule

// File: rtl/rtc_irq_dp.sv
module rtc_irq_dp
  import rtc_irq_pkg::*;
#(
  parameter int NUM_TICKS = 6,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_TICKS-1:0] tickIn,
  input  logic                 alarmEvt,
  input  logic                 pwrFail,
  input  logic                 chipSel,
  input  logic [DATA_W-1:0]    wrData,
  input  strobes_t             stb,
  output logic                 bankSel,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqN
);
  logic [NUM_TICKS-1:0] perFlags, perEn;
  logic perPend, alarmPend, alarmEn, pfBit, pfEn, irqActive;
  logic [DATA_W-1:0] outMode, mainVal;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_TICKS; gi++) begin : g_flag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) perFlags[gi] <= 1'b0;
        else       perFlags[gi] <= tickIn[gi] | (perFlags[gi] & ~stb.perAccess);
      end
      // R2: a tick always lands in its flag
      a_r2_tick_sets: assert property (@(posedge clk) disable iff (!rstN)
        tickIn[gi] |=> perFlags[gi]);
      // R3: access without a coincident tick empties the flag
      a_r3_access_clears: assert property (@(posedge clk) disable iff (!rstN)
        (stb.perAccess && !tickIn[gi]) |=> !perFlags[gi]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perPend <= 1'b0; alarmPend <= 1'b0; pfBit <= 1'b0;
      perEn <= '0; alarmEn <= 1'b0; pfEn <= 1'b0;
      bankSel <= 1'b0; outMode <= '0;
    end else begin
      perPend   <= (perPend & ~(stb.mainWr & wrData[MS_PER])) | (|(tickIn & perEn));
      alarmPend <= (alarmPend & ~(stb.mainWr & wrData[MS_ALARM])) | alarmEvt;
      pfBit     <= pwrFail & (pfBit | (pfEn & ~chipSel));
      if (stb.mainWr) bankSel <= wrData[MS_BANK];
      if (stb.icr0Wr) perEn <= wrData[NUM_TICKS-1:0];
      if (stb.icr1Wr) begin
        alarmEn <= wrData[0];
        pfEn    <= wrData[1];
      end
      if (stb.omWr) outMode <= wrData;
    end
  end

  assign irqActive = pfBit | perPend | (alarmPend & alarmEn);
  assign irqN      = ~irqActive;

  always_comb begin
    mainVal           = '0;
    mainVal[MS_IRQ]   = irqActive;
    mainVal[MS_PFAIL] = pfBit;
    mainVal[MS_PER]   = perPend;
    mainVal[MS_ALARM] = alarmPend;
    mainVal[MS_BANK]  = bankSel;
    unique case (stb.rdSel)
      RS_MAIN:  rdData = mainVal;
      RS_PFLAG: rdData = DATA_W'(perFlags);
      RS_ICR0:  rdData = DATA_W'(perEn);
      RS_ICR1:  rdData = DATA_W'({pfEn, alarmEn});
      RS_OMODE: rdData = outMode;
      default:  rdData = '0;
    endcase
  end

  // R5: pending periodic bit survives anything but a written one
  a_r5_pend_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (perPend && !(stb.mainWr && wrData[MS_PER])) |=> perPend);
  // R6: alarm event always records
  a_r6_alarm_sets: assert property (@(posedge clk) disable iff (!rstN)
    alarmEvt |=> alarmPend);
  // R7: power-fail bit drops once the sense input is released
  a_r7_pf_release: assert property (@(posedge clk) disable iff (!rstN)
    !pwrFail |=> !pfBit);
  // R7: power-fail bit only rises with the enable on and no access in progress
  a_r7_pf_gated: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pfBit) |-> $past(pfEn && !chipSel));
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
  import rtc_irq_pkg::*;
#(
  parameter int NUM_TICKS = 6,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_TICKS-1:0] tickIn,
  input  logic                 alarmEvt,
  input  logic                 pwrFail,
  input  logic                 chipSel,
  input  logic                 rdEn,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqN
);
  strobes_t stb;
  logic     bankSel;

  rtc_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .chipSel(chipSel), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .bankSel(bankSel), .stb(stb)
  );

  rtc_irq_dp #(.NUM_TICKS(NUM_TICKS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .alarmEvt(alarmEvt),
    .pwrFail(pwrFail), .chipSel(chipSel), .wrData(wrData), .stb(stb),
    .bankSel(bankSel), .rdData(rdData), .irqN(irqN)
  );
endmodule

// File: tb/rtc_irq_status_tb.sv
`timescale 1ns/1ps
module rtc_irq_status_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic [5:0] tickIn = '0;
  logic alarmEvt = 1'b0, pwrFail = 1'b0, chipSel = 1'b0, rdEn = 1'b0, wrEn = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wrData = '0, rdData, rv;
  logic irqN;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_irq_status u_dut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .alarmEvt(alarmEvt), .pwrFail(pwrFail),
    .chipSel(chipSel), .rdEn(rdEn), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irqN(irqN)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busOp(input bit cs, input bit wr, input logic [4:0] a,
                       input logic [7:0] d, input logic [5:0] tk, output logic [7:0] rd);
    @(negedge clk);
    chipSel = cs; wrEn = wr; rdEn = !wr; addr = a; wrData = d; tickIn = tk;
    #1 rd = rdData;
    @(negedge clk);
    chipSel = 0; wrEn = 0; rdEn = 0; tickIn = '0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    busOp(1'b1, 1'b1, a, d, '0, dummy);
  endtask

  task automatic rdChk(input string req, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] got;
    busOp(1'b1, 1'b0, a, 8'h00, '0, got);
    chk(req, got, exp);
  endtask

  task automatic pulseTick(input logic [5:0] m);
    @(negedge clk); tickIn = m;
    @(negedge clk); tickIn = '0;
  endtask

  task automatic t_reset();
    chk("R1 irqN after reset", {7'd0, irqN}, 8'h01);
    rdChk("R1 main status", 5'h00, 8'h00);
    rdChk("R1 periodic flags", 5'h03, 8'h00);
  endtask

  task automatic t_flags();
    pulseTick(6'b001001);
    chk("R4 disabled ticks leave irqN", {7'd0, irqN}, 8'h01);
    rdChk("R2 flags with enables off", 5'h03, 8'h09);
    rdChk("R3 read cleared flags", 5'h03, 8'h00);
    rdChk("R4 no pending from disabled ticks", 5'h00, 8'h00);
    pulseTick(6'b000100);
    wr(5'h03, 8'hFF);
    rdChk("R3 write clears flags", 5'h03, 8'h00);
    pulseTick(6'b100000);
    busOp(1'b1, 1'b0, 5'h03, 8'h00, 6'b000010, rv);
    chk("R3 read shows pre-clear value", rv, 8'h20);
    rdChk("R3 coincident tick survives", 5'h03, 8'h02);
  endtask

  task automatic t_periodic();
    wr(5'h00, 8'h40);
    wr(5'h03, 8'h04);
    rdChk("R9 bank1 03h is enable reg", 5'h03, 8'h04);
    rdChk("R9 main readable in bank1", 5'h00, 8'h40);
    pulseTick(6'b000001);
    chk("R4 unenabled tick no irq", {7'd0, irqN}, 8'h01);
    pulseTick(6'b000100);
    chk("R8 enabled tick drives irqN", {7'd0, irqN}, 8'h00);
    rdChk("R4 pending and summary set", 5'h00, 8'h45);
    wr(5'h03, 8'h00);
    chk("R5 pending survives enables off", {7'd0, irqN}, 8'h00);
    wr(5'h00, 8'h40);
    rdChk("R5 writing zero keeps pending", 5'h00, 8'h45);
    wr(5'h00, 8'h44);
    chk("R5 write one drops irq", {7'd0, irqN}, 8'h01);
    rdChk("R5 pending cleared", 5'h00, 8'h40);
    wr(5'h00, 8'h00);
    rdChk("R9 bank0 03h is flags, uncleared", 5'h03, 8'h05);
  endtask

  task automatic t_alarm();
    @(negedge clk); alarmEvt = 1;
    @(negedge clk); alarmEvt = 0;
    chk("R6 alarm without enable no irq", {7'd0, irqN}, 8'h01);
    rdChk("R6 alarm bit set", 5'h00, 8'h08);
    wr(5'h00, 8'h40);
    rdChk("R6 zero write keeps alarm", 5'h00, 8'h48);
    wr(5'h04, 8'h01);
    chk("R6 enabling routes alarm", {7'd0, irqN}, 8'h00);
    rdChk("R8 summary with alarm", 5'h00, 8'h49);
    wr(5'h00, 8'h48);
    chk("R6 alarm cleared irq", {7'd0, irqN}, 8'h01);
    rdChk("R6 alarm bit cleared", 5'h00, 8'h40);
  endtask

  task automatic t_pfail();
    wr(5'h04, 8'h02);
    rdChk("R7 enable readback", 5'h04, 8'h02);
    @(negedge clk); chipSel = 1; pwrFail = 1;
    repeat (3) begin
      @(negedge clk);
      chk("R7 chipSel gates power fail", {7'd0, irqN}, 8'h01);
    end
    chipSel = 0;
    @(negedge clk);
    chk("R7 power fail irq", {7'd0, irqN}, 8'h00);
    rdChk("R7 power fail status", 5'h00, 8'h43);
    chk("R7 holds during access", {7'd0, irqN}, 8'h00);
    @(negedge clk); pwrFail = 0;
    @(negedge clk);
    chk("R7 released on power restore", {7'd0, irqN}, 8'h01);
    rdChk("R7 status cleared", 5'h00, 8'h40);
  endtask

  task automatic t_outmode();
    wr(5'h02, 8'hA5);
    rdChk("R10 output mode readback", 5'h02, 8'hA5);
    chk("R10 no irq effect", {7'd0, irqN}, 8'h01);
  endtask

  task automatic t_nocs();
    busOp(1'b0, 1'b1, 5'h03, 8'hFF, '0, rv);
    rdChk("R11 write without cs ignored", 5'h03, 8'h00);
    busOp(1'b0, 1'b0, 5'h02, 8'h00, '0, rv);
    chk("R11 read without cs is zero", rv, 8'h00);
    rdChk("R11 unmapped reads zero", 5'h07, 8'h00);
    wr(5'h00, 8'h00);
    pulseTick(6'b010000);
    busOp(1'b0, 1'b0, 5'h03, 8'h00, '0, rv);
    rdChk("R11 flags kept without cs", 5'h03, 8'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_flags();
    t_periodic();
    t_alarm();
    t_pfail();
    t_outmode();
    t_nocs();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule